// File: doc/BRIEF.md
# Anti-Diagonal Wavefront Scheduler

This block sequences a single, self-contained processing element through a complete dynamic-programming matrix of R rows by C columns. It hands one cell coordinate per slot to a compute pipeline of fixed depth P. The matrix is visited one anti-diagonal at a time, because every cell needs results from two neighbours on the diagonal before it, while cells that share a diagonal are mutually independent and can follow each other with no gap.

A diagonal shorter than P would let the first cell of the next diagonal enter the pipeline before the first cell of the current diagonal has come out. To prevent this, the scheduler pads such a diagonal with idle slots (bubbles), so no forwarding logic is needed. Bubbles therefore only occur while the wavefront ramps up and ramps down. A downstream ready input gates every slot. A fixed-latency delay line of depth P stands in for the arithmetic datapath and shows when each issued cell retires.

Top module: `wf_sched`

## Requirements
- R1: After reset, valid_o, bubble_o, done_o and retire_valid_o are all low.
- R2: A start_i pulse with nonzero rows_i and cols_i, while idle, latches the dimensions, and cell (0,0) on diagonal 0 is offered in the next cycle. A start_i that arrives while a task is running, or that carries a zero dimension, has no effect.
- R3: Cells are offered diagonal by diagonal, from k = 0 up to k = R+C-2. On diagonal k, row_o rises one step at a time from max(0, k-C+1) to min(k, R-1), col_o equals k minus row_o, and diag_o equals k.
- R4: A slot is consumed only on a clock edge where ready_i is high. While ready_i is low, valid_o, bubble_o, row_o, col_o and diag_o hold their values.
- R5: After a diagonal of L cells with L < P, exactly P-L bubble slots follow (bubble_o high, valid_o low). A diagonal with L >= P, and the final diagonal, get no bubbles. valid_o and bubble_o are never high together.
- R6: Between the consumed slots that carry the first cells of diagonals k and k+1 there are exactly max(L_k, P) slots, and never fewer than P.
- R7: When R >= P and C >= P, one task contains exactly (P-1)^2 bubble slots, whatever the values of R and C.
- R8: done_o is high for exactly one cycle, in the cycle after the slot carrying cell (R-1, C-1) is consumed. Outputs are idle in that cycle, and the block then accepts a new start.
- R9: Each consumed slot reappears on the retire outputs P consumed slots later. A cell appears with retire_valid_o high and its row and column; a bubble appears with retire_valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a task with the given dimensions |
| rows_i | input | ROW_W+1 | Row count R (1 to 2^ROW_W) |
| cols_i | input | COL_W+1 | Column count C (1 to 2^COL_W) |
| ready_i | input | 1 | Downstream accepts the current slot |
| valid_o | output | 1 | Current slot carries a cell |
| bubble_o | output | 1 | Current slot is an idle slot |
| row_o | output | ROW_W | Row index of the offered cell |
| col_o | output | COL_W | Column index of the offered cell |
| diag_o | output | DIAG_W | Anti-diagonal number of the offered cell |
| done_o | output | 1 | One-cycle pulse after the last cell is consumed |
| retire_valid_o | output | 1 | Cell leaving the stand-in pipeline |
| retire_row_o | output | ROW_W | Row of the retiring cell |
| retire_col_o | output | COL_W | Column of the retiring cell |

## Verification
The bench sweeps every matrix shape from 1x1 to 10x10 with P = 8. This covers single-row and single-column matrices, where every diagonal has one cell and needs P-1 bubbles, and matrices whose middle diagonals are exactly P cells long and need none. A design that pads the final diagonal would fail to raise done in the expected cycle. A design that computes the pad from the wrong length would break the exact spacing between first cells and the fixed bubble total for large matrices. Half of the shapes run with ready dropping at random, including inside bubble runs, which exposes a counter that advances during a stall. A start arriving mid-task, and starts with zero dimensions, must leave the issued sequence untouched.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CELL = 2'd1,
    ST_PAD  = 2'd2
  } wf_state_e;
endpackage

// File: rtl/wf_rst_sync.sv
module wf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/wf_diag_bounds.sv
// Row and column limits of one anti-diagonal k of an R x C matrix.
module wf_diag_bounds #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DIAG_W = 5
) (
  input  logic [DIAG_W-1:0] diag_i,
  input  logic [ROW_W:0]    rows_i,
  input  logic [COL_W:0]    cols_i,
  output logic [ROW_W-1:0]  row_first_o,
  output logic [ROW_W-1:0]  row_last_o,
  output logic [COL_W-1:0]  col_first_o
);
  localparam int EW = DIAG_W + 2;

  logic [EW-1:0] k_x;
  logic [EW-1:0] r_x;
  logic [EW-1:0] c_x;

  assign k_x = EW'(diag_i);
  assign r_x = EW'(rows_i);
  assign c_x = EW'(cols_i);

  always_comb begin
    row_first_o = (k_x >= c_x) ? ROW_W'(k_x - c_x + EW'(1)) : '0;
    row_last_o  = (k_x <  r_x) ? ROW_W'(k_x) : ROW_W'(r_x - EW'(1));
    col_first_o = (k_x <  c_x) ? COL_W'(k_x) : COL_W'(c_x - EW'(1));
  end
endmodule

// File: rtl/wf_pad_calc.sv
// Number of idle slots owed after a diagonal of len_i cells.
module wf_pad_calc #(
  parameter int PIPE_DEPTH = 8,
  parameter int LEN_W      = 5,
  parameter int PAD_W      = 4
) (
  input  logic [LEN_W-1:0] len_i,
  output logic             need_pad_o,
  output logic [PAD_W-1:0] pad_o
);
  localparam int XW = ((LEN_W > PAD_W) ? LEN_W : PAD_W) + 1;

  logic [XW-1:0] len_x;
  logic [XW-1:0] depth_x;

  assign len_x   = XW'(len_i);
  assign depth_x = XW'(PIPE_DEPTH);

  always_comb begin
    need_pad_o = (len_x < depth_x);
    pad_o      = need_pad_o ? PAD_W'(depth_x - len_x) : '0;
  end
endmodule

// File: rtl/wf_delay_line.sv
// Fixed-latency stand-in for the compute pipeline; shifts once per consumed slot.
module wf_delay_line #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  generate
    if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= '0;
        end else if (adv_en) begin
          stage_q <= din;
        end
      end
      assign dout = stage_q;
    end else begin : g_chain
      logic [DEPTH-1:0][WIDTH-1:0] line_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          line_q <= '0;
        end else if (adv_en) begin
          line_q <= {line_q[DEPTH-2:0], din};
        end
      end
      assign dout = line_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/wf_sched.sv
module wf_sched
  import wf_pkg::*;
#(
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int PIPE_DEPTH = 8,
  localparam int DIAG_W    = ((ROW_W > COL_W) ? ROW_W : COL_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ROW_W:0]    rows_i,
  input  logic [COL_W:0]    cols_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              bubble_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [DIAG_W-1:0] diag_o,
  output logic              done_o,
  output logic              retire_valid_o,
  output logic [ROW_W-1:0]  retire_row_o,
  output logic [COL_W-1:0]  retire_col_o
);
  localparam int LEN_W = ROW_W + 1;
  localparam int PAD_W = $clog2(PIPE_DEPTH + 1);
  localparam int SW    = DIAG_W + 1;
  localparam int RW    = 1 + ROW_W + COL_W;

  logic rst_sync_n;

  wf_state_e         state_q, state_d;
  logic [ROW_W:0]    rows_q, rows_d;
  logic [COL_W:0]    cols_q, cols_d;
  logic [DIAG_W-1:0] diag_q, diag_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [ROW_W-1:0]  row_last_q, row_last_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [PAD_W-1:0]  pad_q, pad_d;
  logic              done_q, done_d;

  logic              start_ok;
  logic              step_en;
  logic              at_last_diag;
  logic [SW-1:0]     last_diag_x;
  logic [DIAG_W-1:0] diag_next;
  logic [ROW_W-1:0]  nb_row_first;
  logic [ROW_W-1:0]  nb_row_last;
  logic [COL_W-1:0]  nb_col_first;
  logic              need_pad;
  logic [PAD_W-1:0]  pad_cnt;
  logic [RW-1:0]     retire_w;

  wf_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign diag_next = diag_q + 1'b1;

  wf_diag_bounds #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DIAG_W (DIAG_W)
  ) u_bounds (
    .diag_i      (diag_next),
    .rows_i      (rows_q),
    .cols_i      (cols_q),
    .row_first_o (nb_row_first),
    .row_last_o  (nb_row_last),
    .col_first_o (nb_col_first)
  );

  wf_pad_calc #(
    .PIPE_DEPTH (PIPE_DEPTH),
    .LEN_W      (LEN_W),
    .PAD_W      (PAD_W)
  ) u_pad (
    .len_i      (cnt_q + LEN_W'(1)),
    .need_pad_o (need_pad),
    .pad_o      (pad_cnt)
  );

  assign start_ok     = start_i && (rows_i != '0) && (cols_i != '0);
  assign last_diag_x  = SW'(rows_q) + SW'(cols_q) - SW'(2);
  assign at_last_diag = (SW'(diag_q) == last_diag_x);
  assign step_en      = (state_q == ST_IDLE) ? start_ok : ready_i;

  // Next-state logic; takes effect only on step_en.
  always_comb begin
    state_d    = state_q;
    rows_d     = rows_q;
    cols_d     = cols_q;
    diag_d     = diag_q;
    row_d      = row_q;
    row_last_d = row_last_q;
    col_d      = col_q;
    cnt_d      = cnt_q;
    pad_d      = pad_q;
    done_d     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        state_d    = ST_CELL;
        rows_d     = rows_i;
        cols_d     = cols_i;
        diag_d     = '0;
        row_d      = '0;
        row_last_d = '0;
        col_d      = '0;
        cnt_d      = '0;
        pad_d      = '0;
      end
      ST_CELL: begin
        if (row_q != row_last_q) begin
          row_d = row_q + 1'b1;
          col_d = col_q - 1'b1;
          cnt_d = cnt_q + 1'b1;
        end else if (at_last_diag) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (need_pad) begin
          state_d = ST_PAD;
          pad_d   = pad_cnt;
        end else begin
          state_d    = ST_CELL;
          diag_d     = diag_next;
          row_d      = nb_row_first;
          row_last_d = nb_row_last;
          col_d      = nb_col_first;
          cnt_d      = '0;
        end
      end
      ST_PAD: begin
        if (pad_q == PAD_W'(1)) begin
          state_d    = ST_CELL;
          diag_d     = diag_next;
          row_d      = nb_row_first;
          row_last_d = nb_row_last;
          col_d      = nb_col_first;
          cnt_d      = '0;
          pad_d      = '0;
        end else begin
          pad_d = pad_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_IDLE;
      rows_q     <= '0;
      cols_q     <= '0;
      diag_q     <= '0;
      row_q      <= '0;
      row_last_q <= '0;
      col_q      <= '0;
      cnt_q      <= '0;
      pad_q      <= '0;
    end else if (step_en) begin
      state_q    <= state_d;
      rows_q     <= rows_d;
      cols_q     <= cols_d;
      diag_q     <= diag_d;
      row_q      <= row_d;
      row_last_q <= row_last_d;
      col_q      <= col_d;
      cnt_q      <= cnt_d;
      pad_q      <= pad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= step_en && done_d;
    end
  end

  assign valid_o  = (state_q == ST_CELL);
  assign bubble_o = (state_q == ST_PAD);
  assign row_o    = row_q;
  assign col_o    = col_q;
  assign diag_o   = diag_q;
  assign done_o   = done_q;

  wf_delay_line #(
    .DEPTH (PIPE_DEPTH),
    .WIDTH (RW)
  ) u_stand_in (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .adv_en (ready_i),
    .din    ({valid_o, row_q, col_q}),
    .dout   (retire_w)
  );

  assign retire_valid_o = retire_w[RW-1];
  assign retire_row_o   = retire_w[RW-2 -: ROW_W];
  assign retire_col_o   = retire_w[COL_W-1:0];
endmodule

// File: rtl/wf_sched_chk.sv
module wf_sched_chk #(
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int PIPE_DEPTH = 8,
  localparam int DIAG_W    = ((ROW_W > COL_W) ? ROW_W : COL_W) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready_i,
  input logic              valid_o,
  input logic              bubble_o,
  input logic [ROW_W-1:0]  row_o,
  input logic [COL_W-1:0]  col_o,
  input logic [DIAG_W-1:0] diag_o,
  input logic              done_o
);
  localparam int GW = $clog2(PIPE_DEPTH + 1) + 1;

  logic [GW-1:0]     gap_q;
  logic [DIAG_W-1:0] last_diag_q;
  logic              seen_q;
  logic              first_issue;

  assign first_issue = valid_o && ready_i && (!seen_q || (diag_o != last_diag_q));

  // Slots consumed since the first cell of the current diagonal.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q       <= '0;
      last_diag_q <= '0;
      seen_q      <= 1'b0;
    end else if (done_o) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (ready_i) begin
      if (first_issue) begin
        gap_q       <= GW'(1);
        last_diag_q <= diag_o;
        seen_q      <= 1'b1;
      end else if (gap_q < GW'(PIPE_DEPTH)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && bubble_o));

  p_diag_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((DIAG_W'(row_o) + DIAG_W'(col_o)) == diag_o));

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_o || bubble_o) && !ready_i) |=>
      ($stable(valid_o) && $stable(bubble_o) && $stable(row_o) &&
       $stable(col_o) && $stable(diag_o)));

  p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (first_issue && seen_q) |-> (gap_q >= GW'(PIPE_DEPTH)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!valid_o && !bubble_o));
endmodule

bind wf_sched wf_sched_chk #(
  .ROW_W      (ROW_W),
  .COL_W      (COL_W),
  .PIPE_DEPTH (PIPE_DEPTH)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready_i  (ready_i),
  .valid_o  (valid_o),
  .bubble_o (bubble_o),
  .row_o    (row_o),
  .col_o    (col_o),
  .diag_o   (diag_o),
  .done_o   (done_o)
);

// File: tb/wf_sched_tb_top.sv
module wf_sched_tb_top;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int P      = 8;
  localparam int DIAG_W = 5;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [ROW_W:0]    rows_i;
  logic [COL_W:0]    cols_i;
  logic              ready_i;
  logic              valid_o;
  logic              bubble_o;
  logic [ROW_W-1:0]  row_o;
  logic [COL_W-1:0]  col_o;
  logic [DIAG_W-1:0] diag_o;
  logic              done_o;
  logic              retire_valid_o;
  logic [ROW_W-1:0]  retire_row_o;
  logic [COL_W-1:0]  retire_col_o;

  int n_chk;
  int n_fail;
  int slot_n;
  int ready_mode;
  int inject_at;
  int obs_bub;
  int obs_last_diag;
  int obs_first_slot;
  int obs_spacing_bad;
  logic [15:0] lfsr;
  int hist_v [64];
  int hist_r [64];
  int hist_c [64];

  wf_sched #(
    .ROW_W      (ROW_W),
    .COL_W      (COL_W),
    .PIPE_DEPTH (P)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .rows_i         (rows_i),
    .cols_i         (cols_i),
    .ready_i        (ready_i),
    .valid_o        (valid_o),
    .bubble_o       (bubble_o),
    .row_o          (row_o),
    .col_o          (col_o),
    .diag_o         (diag_o),
    .done_o         (done_o),
    .retire_valid_o (retire_valid_o),
    .retire_row_o   (retire_row_o),
    .retire_col_o   (retire_col_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pick_ready();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (ready_mode == 0) return 1'b1;
    return (lfsr[1:0] != 2'b00);
  endfunction

  // Offer one expected slot; waits through stalls until it is consumed.
  task automatic slot(input bit ev, input int r, input int c, input int k);
    bit waited = 1'b0;
    bit took;
    forever begin
      took = pick_ready();
      ready_i = took;
      if (slot_n == inject_at) begin
        start_i = 1'b1;       // R2: mid-task start must be ignored
        rows_i  = 5'd2;
        cols_i  = 5'd2;
      end else begin
        start_i = 1'b0;
      end
      check({valid_o, bubble_o} == {ev, !ev}, waited ? "R4 hold" : (ev ? "R3 kind" : "R5 bubble"),
            int'({valid_o, bubble_o}), int'({ev, !ev}));
      if (ev) begin
        check(int'(row_o) == r, waited ? "R4 row" : "R3 row", int'(row_o), r);
        check(int'(col_o) == c, waited ? "R4 col" : "R3 col", int'(col_o), c);
        check(int'(diag_o) == k, waited ? "R4 diag" : "R3 diag", int'(diag_o), k);
      end
      if (took) begin
        if (slot_n >= P) begin
          int h = (slot_n - P) % 64;
          check(int'(retire_valid_o) == hist_v[h], "R9 retire valid", int'(retire_valid_o), hist_v[h]);
          if (hist_v[h] != 0) begin
            check(int'(retire_row_o) == hist_r[h], "R9 retire row", int'(retire_row_o), hist_r[h]);
            check(int'(retire_col_o) == hist_c[h], "R9 retire col", int'(retire_col_o), hist_c[h]);
          end
        end
        hist_v[slot_n % 64] = int'(ev);
        hist_r[slot_n % 64] = r;
        hist_c[slot_n % 64] = c;
        if (bubble_o) obs_bub++;
        if (valid_o && (obs_last_diag < 0 || int'(diag_o) != obs_last_diag)) begin
          if (obs_last_diag >= 0 && (slot_n - obs_first_slot) < P) obs_spacing_bad++;
          obs_last_diag  = int'(diag_o);
          obs_first_slot = slot_n;
        end
        slot_n++;
      end
      @(negedge clk);
      if (took) break;
      waited = 1'b1;
    end
  endtask

  task automatic run_task(input int R, input int C, input int mode, input int inj);
    int first_prev;
    int len_prev;
    ready_mode = mode;
    inject_at  = inj;
    slot_n     = 0;
    obs_bub    = 0;
    obs_last_diag   = -1;
    obs_first_slot  = 0;
    obs_spacing_bad = 0;
    first_prev = 0;
    len_prev   = 0;
    start_i = 1'b1;
    rows_i  = 5'(R);
    cols_i  = 5'(C);
    ready_i = 1'b1;
    @(negedge clk);
    for (int k = 0; k <= R + C - 2; k++) begin
      int lo = (k - C + 1 > 0) ? k - C + 1 : 0;
      int hi = (k < R - 1) ? k : R - 1;
      int len = hi - lo + 1;
      if (k > 0) begin
        int want = (len_prev > P) ? len_prev : P;
        check(slot_n - first_prev == want, "R6 spacing", slot_n - first_prev, want);
      end
      first_prev = slot_n;
      len_prev   = len;
      for (int r = lo; r <= hi; r++) slot(1'b1, r, k - r, k);
      if (k != R + C - 2 && len < P)
        for (int b = 0; b < P - len; b++) slot(1'b0, 0, 0, k);
    end
    start_i = 1'b0;
    ready_i = 1'b1;
    check(done_o == 1'b1, "R8 done pulse", int'(done_o), 1);
    check(valid_o == 1'b0 && bubble_o == 1'b0, "R8 idle at done", int'({valid_o, bubble_o}), 0);
    check(obs_spacing_bad == 0, "R6 min spacing", obs_spacing_bad, 0);
    if (R >= P && C >= P)
      check(obs_bub == (P - 1) * (P - 1), "R7 bubble total", obs_bub, (P - 1) * (P - 1));
    @(negedge clk);
    check(done_o == 1'b0, "R8 single pulse", int'(done_o), 0);
  endtask

  task automatic zero_dim(input int R, input int C);
    start_i = 1'b1;
    rows_i  = 5'(R);
    cols_i  = 5'(C);
    ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(valid_o == 1'b0 && bubble_o == 1'b0 && done_o == 1'b0, "R2 zero dim ignored",
            int'({valid_o, bubble_o, done_o}), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    lfsr = 16'hACE1;
    inject_at = -1;
    ready_mode = 0;
    start_i = 1'b0;
    rows_i = '0;
    cols_i = '0;
    ready_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid reset", int'(valid_o), 0);
    check(bubble_o == 1'b0, "R1 bubble reset", int'(bubble_o), 0);
    check(done_o == 1'b0, "R1 done reset", int'(done_o), 0);
    check(retire_valid_o == 1'b0, "R1 retire reset", int'(retire_valid_o), 0);

    for (int R = 1; R <= 10; R++)
      for (int C = 1; C <= 10; C++)
        run_task(R, C, (R + C) % 2, (R == 6 && C == 7) ? 5 : -1);

    run_task(9, 8, 1, 3);      // R2 start during task, random stalls
    zero_dim(0, 5);
    zero_dim(4, 0);
    run_task(2, 3, 0, -1);     // R8 block accepts new work afterwards

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule